// File: doc/BRIEF.md
# Bus-Side Restart Injector

This block sits on the data path between a cartridge's program memory and the connector of an 8-bit CPU bus with a 6502-style instruction set. It forces the CPU to restart at the program's reset vector without touching the CPU's reset pin. It watches the address bus, the read/write line and the bus clock phase. It cuts the memory off through an isolation-buffer enable and supplies instruction bytes of its own on the data bus.

The block cannot tell where the CPU is in its instruction stream, so it floods every read with the jump opcode $4C. Whatever byte the CPU takes as an opcode, it soon settles in the loop `JMP $4C4C`. After a minimum number of flooded reads, the next read of $4C4C is known to be an opcode fetch. The block answers that read with the indirect-jump opcode $6C, then supplies the pointer bytes $FC and $FF. It reconnects the memory so that the CPU reads the real vector at $FFFC/$FFFD.

Top module: `restart_injector`

## Requirements
- R1: After reset, and at any time the block is not busy, busy is 0, the memory buffer enable is 1 and the data bus is not driven.
- R2: A trigger seen while idle sets busy on the next clock and clears the memory buffer enable (memory isolated).
- R3: While isolated, each CPU read cycle (read/write high, bus phase high) drives the filler byte $4C, except for the single opcode fetch named in R5.
- R4: At least FILL_MIN (default 8) read cycles are flooded before the indirect jump may start. A read of $4C4C among those first reads still receives $4C.
- R5: After the flood minimum, the first read of address $4C4C receives $6C. The next two read cycles receive $FC and then $FF.
- R6: After the $FF byte, the memory buffer enable returns to 1 and reads of $FFFC and $FFFD are not driven by the block. Busy stays 1 after the $FFFC read and falls once the read of $FFFD has ended.
- R7: Write cycles (read/write low) and the low bus phase never cause the data bus to be driven. Write cycles do not advance the flood count or the sequence.
- R8: A trigger arriving while busy is ignored and does not restart the flood.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than the bus phase |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_phi | input | 1 | CPU bus clock phase; high marks the data part of a cycle |
| bus_addr | input | 16 | CPU address bus (observed only) |
| bus_rd | input | 1 | CPU read/write line, 1 = read |
| mem_rdata | input | 8 | Cartridge memory data output |
| restart_req | input | 1 | Request to restart the CPU |
| inj_data | output | 8 | Byte the block places on the data bus |
| inj_drive | output | 1 | Drive enable for inj_data |
| mem_conn | output | 1 | Isolation buffer enable, 1 = memory connected |
| busy | output | 1 | Restart sequence in progress |

## Verification
The main sequence is tried with a CPU-like run of reads that cycles through $4C4C, $4C4D and $4C4E from the first flooded read. In that run an early read of $4C4C must still get $4C, which separates a design that counts its flood minimum from one that jumps at the first matching address. A second run mixes write cycles into the flood. It places the $4C4C read so that it would complete the minimum only if writes were counted, which shows whether writes advance the count. A third run re-triggers after the flood minimum. An immediate $6C on the next $4C4C read shows the request was ignored rather than restarting the flood. The handover reads of $FFFC and $FFFD check that memory is reconnected and that busy ends only with the second vector byte.

// File: rtl/inj_pkg.sv
package inj_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_FILL = 3'd1,
      ST_SYNC = 3'd2,
      ST_VLO  = 3'd3,
      ST_VHI  = 3'd4,
      ST_PASS = 3'd5
   } inj_state_e;

   function automatic logic is_isolated(input inj_state_e s);
      return (s == ST_FILL) || (s == ST_SYNC) || (s == ST_VLO) || (s == ST_VHI);
   endfunction
endpackage

// File: rtl/inj_phase_track.sv
module inj_phase_track #(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_phi,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   output logic              cyc_end,
   output logic              cyc_rd,
   output logic [ADDR_W-1:0] cyc_addr
);
   logic phi_s;
   logic phi_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign phi_s = bus_phi;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], bus_phi};
         end
         assign phi_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phi_q    <= 1'b0;
         cyc_rd   <= 1'b0;
         cyc_addr <= '0;
      end else begin
         phi_q <= phi_s;
         if (bus_phi) begin
            cyc_rd   <= bus_rd;
            cyc_addr <= bus_addr;
         end
      end
   end

   assign cyc_end = phi_q & ~phi_s;
endmodule

// File: rtl/inj_sequencer.sv
module inj_sequencer
   import inj_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          FILL_MIN  = 8,
   parameter logic [15:0] LOOP_ADDR = 16'h4C4C,
   parameter logic [15:0] VEC_ADDR  = 16'hFFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_req,
   input  logic              cyc_end,
   input  logic              cyc_rd,
   input  logic [ADDR_W-1:0] cyc_addr,
   output inj_state_e        state
);
   localparam int CNT_W = $clog2(FILL_MIN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILL_MIN);
   localparam logic [ADDR_W-1:0] LOOP_A = ADDR_W'(LOOP_ADDR);
   localparam logic [ADDR_W-1:0] VEC_HI = ADDR_W'(VEC_ADDR + 16'd1);

   logic [CNT_W-1:0] fill_cnt;
   logic             rd_end;
   inj_state_e       state_nx;

   assign rd_end = cyc_end & cyc_rd;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (restart_req) state_nx = ST_FILL;
         ST_FILL: if (rd_end && fill_cnt == CNT_MAX - 1'b1) state_nx = ST_SYNC;
         ST_SYNC: if (rd_end && cyc_addr == LOOP_A) state_nx = ST_VLO;
         ST_VLO:  if (rd_end) state_nx = ST_VHI;
         ST_VHI:  if (rd_end) state_nx = ST_PASS;
         ST_PASS: if (rd_end && cyc_addr == VEC_HI) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fill_cnt <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE)
            fill_cnt <= '0;
         else if (state == ST_FILL && rd_end && fill_cnt != CNT_MAX)
            fill_cnt <= fill_cnt + 1'b1;
      end
   end

   a_r2_trigger_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && restart_req) |=> state == ST_FILL);

   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && state != ST_FILL && restart_req) |=> state != ST_FILL);

   a_r4_fill_len: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && state_nx == ST_SYNC) |-> fill_cnt == CNT_MAX - 1'b1);

   a_r5_ptr_order: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_VLO && rd_end) |=> state == ST_VHI);

   a_r7_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && !cyc_rd && state != ST_IDLE) |=> $stable(fill_cnt));
endmodule

// File: rtl/inj_bus_mux.sv
module inj_bus_mux
   import inj_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 8,
   parameter logic [7:0]  LOOP_OPC  = 8'h4C,
   parameter logic [7:0]  IND_OPC   = 8'h6C,
   parameter logic [15:0] VEC_ADDR  = 16'hFFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  inj_state_e        state,
   input  logic              bus_phi,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] inj_data,
   output logic              inj_drive,
   output logic              mem_conn
);
   localparam logic [ADDR_W-1:0] LOOP_A = ADDR_W'({LOOP_OPC, LOOP_OPC});

   logic isolated;
   assign isolated  = is_isolated(state);
   assign mem_conn  = ~isolated;
   assign inj_drive = isolated & bus_phi & bus_rd;

   always_comb begin
      unique case (state)
         ST_FILL: inj_data = DATA_W'(LOOP_OPC);
         ST_SYNC: inj_data = (bus_addr == LOOP_A) ? DATA_W'(IND_OPC) : DATA_W'(LOOP_OPC);
         ST_VLO:  inj_data = DATA_W'(VEC_ADDR[7:0]);
         ST_VHI:  inj_data = DATA_W'(VEC_ADDR[15:8]);
         default: inj_data = '0;
      endcase
   end

   a_r7_no_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || !bus_phi) |-> !inj_drive);

   a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      inj_drive |-> !mem_conn);
endmodule

// File: rtl/restart_injector.sv
module restart_injector #(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 8,
   parameter int          FILL_MIN    = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [7:0]  LOOP_OPC    = 8'h4C,
   parameter logic [7:0]  IND_OPC     = 8'h6C,
   parameter logic [15:0] VEC_ADDR    = 16'hFFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_phi,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              restart_req,
   output logic [DATA_W-1:0] inj_data,
   output logic              inj_drive,
   output logic              mem_conn,
   output logic              busy
);
   import inj_pkg::*;

   localparam logic [15:0] LOOP_ADDR = {LOOP_OPC, LOOP_OPC};

   generate
      if (FILL_MIN < 4) begin : g_bad_fill
         $error("FILL_MIN must cover one corrupted instruction (>= 4)");
      end
      if (ADDR_W != 16 || DATA_W != 8) begin : g_bad_bus
         $error("bus widths must be 16 address and 8 data bits");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0, 2, 3 or 4");
      end
   endgenerate

   logic              cyc_end;
   logic              cyc_rd;
   logic [ADDR_W-1:0] cyc_addr;
   inj_state_e        state;
   logic [DATA_W-1:0] unused_mem;

   assign unused_mem = mem_rdata;

   inj_phase_track #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_phase (
      .clk(clk), .rst_n(rst_n), .bus_phi(bus_phi), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .cyc_end(cyc_end), .cyc_rd(cyc_rd), .cyc_addr(cyc_addr)
   );

   inj_sequencer #(.ADDR_W(ADDR_W), .FILL_MIN(FILL_MIN),
                   .LOOP_ADDR(LOOP_ADDR), .VEC_ADDR(VEC_ADDR)) u_seq (
      .clk(clk), .rst_n(rst_n), .restart_req(restart_req), .cyc_end(cyc_end),
      .cyc_rd(cyc_rd), .cyc_addr(cyc_addr), .state(state)
   );

   inj_bus_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOOP_OPC(LOOP_OPC),
                 .IND_OPC(IND_OPC), .VEC_ADDR(VEC_ADDR)) u_mux (
      .clk(clk), .rst_n(rst_n), .state(state), .bus_phi(bus_phi),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .inj_data(inj_data),
      .inj_drive(inj_drive), .mem_conn(mem_conn)
   );

   assign busy = (state != ST_IDLE);

   a_r1_idle_connected: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_conn && !inj_drive));

   a_r6_vector_released: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mem_conn) |-> !inj_drive);
endmodule

// File: tb/sim_restart_injector.sv
module sim_restart_injector;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_phi = 1'b0;
   logic [15:0] bus_addr = 16'h0000;
   logic        bus_rd = 1'b1;
   logic [7:0]  mem_rdata = 8'hEA;
   logic        restart_req = 1'b0;
   logic [7:0]  inj_data;
   logic        inj_drive;
   logic        mem_conn;
   logic        busy;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   restart_injector u0 (
      .clk(clk), .rst_n(rst_n), .bus_phi(bus_phi), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .mem_rdata(mem_rdata), .restart_req(restart_req),
      .inj_data(inj_data), .inj_drive(inj_drive), .mem_conn(mem_conn), .busy(busy)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one read cycle; exp_drive/exp_data checked mid high phase
   task automatic rd_cyc(input logic [15:0] a, input bit exp_drive, input logic [7:0] exp_data,
                         input string req);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1; bus_phi = 1'b0;
      @(negedge clk);
      chk("R7", "drive in low phase", inj_drive, 0);
      @(negedge clk); bus_phi = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(req, $sformatf("drive @%h", a), inj_drive, exp_drive);
      if (exp_drive) chk(req, $sformatf("data @%h", a), inj_data, exp_data);
      @(negedge clk); @(negedge clk); bus_phi = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic wr_cyc(input logic [15:0] a);
      @(negedge clk); bus_addr = a; bus_rd = 1'b0; bus_phi = 1'b0;
      @(negedge clk); @(negedge clk); bus_phi = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R7", "drive on write", inj_drive, 0);
      @(negedge clk); @(negedge clk); bus_phi = 1'b0;
      repeat (4) @(negedge clk);
      bus_rd = 1'b1;
   endtask

   task automatic pulse_req();
      @(negedge clk); restart_req = 1'b1;
      @(negedge clk); restart_req = 1'b0;
   endtask

   task automatic handover();
      rd_cyc(16'h4C4C, 1, 8'h6C, "R5");
      rd_cyc(16'h4C4D, 1, 8'hFC, "R5");
      rd_cyc(16'h4C4E, 1, 8'hFF, "R5");
      chk("R6", "mem_conn after ptr", mem_conn, 1);
      rd_cyc(16'hFFFC, 0, 8'h00, "R6");
      chk("R6", "busy after FFFC", busy, 1);
      rd_cyc(16'hFFFD, 0, 8'h00, "R6");
      chk("R6", "busy after FFFD", busy, 0);
      chk("R1", "mem_conn idle", mem_conn, 1);
   endtask

   task automatic t_reset();
      chk("R1", "busy at reset", busy, 0);
      chk("R1", "mem_conn at reset", mem_conn, 1);
      chk("R1", "drive at reset", inj_drive, 0);
      rd_cyc(16'h8000, 0, 8'h00, "R1");
   endtask

   task automatic t_basic();
      rd_cyc(16'hC123, 0, 8'h00, "R1");
      pulse_req();
      chk("R2", "busy after req", busy, 1);
      chk("R2", "mem isolated", mem_conn, 0);
      for (int i = 0; i < 8; i++)
         rd_cyc(16'h4C4C + 16'(i % 3), 1, 8'h4C, (i % 3 == 0) ? "R4" : "R3");
      rd_cyc(16'h4C4E, 1, 8'h4C, "R3");
      handover();
   endtask

   task automatic t_writes();
      pulse_req();
      for (int i = 0; i < 7; i++) rd_cyc(16'h9000 + 16'(i), 1, 8'h4C, "R3");
      for (int i = 0; i < 5; i++) wr_cyc(16'h0100 + 16'(i));
      rd_cyc(16'h4C4C, 1, 8'h4C, "R7");
      handover();
   endtask

   task automatic t_retrigger();
      pulse_req();
      for (int i = 0; i < 8; i++) rd_cyc(16'hA000 + 16'(i), 1, 8'h4C, "R3");
      pulse_req();
      chk("R8", "busy after retrigger", busy, 1);
      handover();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_basic();
      t_writes();
      t_retrigger();
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule